// File: doc/BRIEF.md
# Serial Readback Checksum Unit with Truncated CRC-16

This block keeps a running CRC over a serial readback stream, taking one data bit per accepted transfer. The remainder uses the generator x^16 + x^12 + x^5 + 1 and starts from zero. When the source marks the final data bit, the block enters a tail phase that covers the eleven most significant remainder bits. In send mode it puts those bits on an output stream, highest first. In compare mode it takes eleven received check bits, compares each one with the matching remainder bit, and reports a sticky mismatch and a result-valid flag.

The three serial paths use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. A source must hold its bit (and `in_last`) steady until that transfer. When the sink holds `out_ready` low, the block keeps `out_valid` and `out_bit` unchanged. The data input takes bits only in the load phase. After the final bit it stays closed until a synchronous clear, and that clear also samples the send/compare mode pin. About one corrupted stream in 2048 can still give the same eleven check bits, because five remainder bits are dropped.

Top module: `rb_crc11_unit`

## Requirements
- R1: After reset or a synchronous clear (`clr` high at a clock edge), the remainder is zero, `in_ready` is 1, and `busy`, `out_valid`, `chk_ready`, `result_valid` and `mismatch` are 0 from the next cycle on. A clear takes priority over all other activity, including an unfinished tail.
- R2: Each accepted data bit updates the 16-bit remainder MSB-first. The feedback is remainder bit 15 XOR the data bit, and the feedback is XORed into taps 0x1021. For the ASCII bytes "123456789", each sent MSB first, the eleven check bits are 0x18E, which is the remainder 0x31C3 shifted right by 5.
- R3: A data bit accepted with `in_last` high ends the data. From the next cycle `busy` is 1, and it stays 1 until exactly 11 tail transfers have taken place.
- R4: In send mode (mode value 0), `out_valid` equals `busy`. `out_bit` gives remainder bits 15 down to 5, one bit per accepted output transfer. While `out_ready` is low, `out_valid` and `out_bit` stay unchanged.
- R5: In compare mode (mode value 1), `chk_ready` equals `busy`. Each accepted `chk_bit` is compared with the next remainder bit, in the same order as R4. `out_valid` is 0 in this mode, and `out_valid` and `chk_ready` are never both 1.
- R6: `mismatch` goes to 1 in the cycle after the first accepted check bit that differs from its expected bit. It then stays 1 until the next clear or reset.
- R7: In compare mode, `result_valid` goes to 1 in the cycle after the 11th check bit is accepted, and it stays 1 until clear. It is never 1 while `busy` is 1.
- R8: `in_ready` is 0 during the tail and after it. Any `in_valid`, `in_bit` or `in_last` activity in that time leaves the check bits and the flags unchanged.
- R9: The `mode_chk` pin is sampled only at a clear. Changing it at any other time has no effect.
- R10: Flipping any single data bit of a stream changes the eleven check bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear; starts a new stream and samples mode_chk |
| mode_chk | input | 1 | 0 = send check bits, 1 = compare received check bits |
| in_valid | input | 1 | Data bit offered |
| in_ready | output | 1 | Data bit can be accepted (load phase) |
| in_bit | input | 1 | Serial data bit |
| in_last | input | 1 | Marks the final data bit |
| out_valid | output | 1 | Check bit offered (send mode tail) |
| out_ready | input | 1 | Sink accepts the check bit |
| out_bit | output | 1 | Serial check bit, remainder bit 15 first |
| chk_valid | input | 1 | Received check bit offered (compare mode) |
| chk_ready | output | 1 | Received check bit can be accepted |
| chk_bit | input | 1 | Received check bit |
| busy | output | 1 | Tail phase in progress |
| result_valid | output | 1 | Compare finished after 11 bits |
| mismatch | output | 1 | Sticky: a received check bit differed |

## Verification
The bench runs the standard check string and expects 0x18E. If the tap set or the bit order is wrong, or the register starts from a nonzero value, the block produces some other value. Output stalls and mode-pin toggles happen mid-stream. A design that let a stalled bit move, or that read the mode pin live, would diverge from the cycle model. During the tail the bench keeps offering data bits, which catches a design that went on folding them into the remainder. A wrong check bit inside the compare window must raise `mismatch` and keep it high through the correct bits that follow. A clear issued halfway through a tail must reopen the data input at once, otherwise the block would stay stuck in the tail.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_TAIL = 2'd1,
    PH_DONE = 2'd2
  } rbc_phase_e;

  localparam int unsigned RBC_CRC_W   = 16;
  localparam logic [15:0] RBC_POLY    = 16'h1021;
  localparam int unsigned RBC_TAIL_N  = 11;

endpackage

// File: rtl/rbc_crc_reg.sv
module rbc_crc_reg #(
  parameter int unsigned    W    = 16,
  parameter logic [W-1:0]   POLY = 16'h1021,
  parameter logic [W-1:0]   INIT = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic feed_en,
  input  logic feed_bit,
  input  logic shift_en,
  output logic msb
);

  logic [W-1:0] rem_q;
  logic [W-1:0] rem_feed;
  logic [W-1:0] rem_shift;
  logic         fb;

  assign fb = rem_q[W-1] ^ feed_bit;

  // one Galois stage per remainder bit; taps chosen by POLY
  for (genvar i = 0; i < int'(W); i++) begin : g_stage
    if (i == 0) begin : g_lsb
      assign rem_feed[i]  = fb & POLY[i];
      assign rem_shift[i] = 1'b0;
    end else begin : g_upper
      assign rem_feed[i]  = rem_q[i-1] ^ (fb & POLY[i]);
      assign rem_shift[i] = rem_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rem_q <= INIT;
    end else if (feed_en) begin
      rem_q <= rem_feed;
    end else if (shift_en) begin
      rem_q <= rem_shift;
    end
  end

  assign msb = rem_q[W-1];

endmodule

// File: rtl/rbc_seq.sv
module rbc_seq
  import rbc_pkg::*;
#(
  parameter int unsigned TAIL_N = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       mode_in,
  input  logic       last_acc,
  input  logic       tail_acc,
  output rbc_phase_e phase,
  output logic       mode_q
);

  localparam int unsigned CNT_W = $clog2(TAIL_N + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TAIL_N - 1);

  rbc_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
    end else if (clr) begin
      phase_q <= PH_LOAD;
      cnt_q   <= '0;
      mode_q  <= mode_in;
    end else begin
      unique case (phase_q)
        PH_LOAD: begin
          if (last_acc) begin
            phase_q <= PH_TAIL;
            cnt_q   <= '0;
          end
        end
        PH_TAIL: begin
          if (tail_acc) begin
            if (cnt_q == LAST_IDX) begin
              phase_q <= PH_DONE;
            end
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          phase_q <= PH_DONE;
        end
      endcase
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/rbc_cmp.sv
module rbc_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cmp_en,
  input  logic rx_bit,
  input  logic ref_bit,
  output logic mismatch
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      mismatch <= 1'b0;
    end else if (cmp_en && (rx_bit != ref_bit)) begin
      mismatch <= 1'b1;
    end
  end

endmodule

// File: rtl/rb_crc11_unit.sv
module rb_crc11_unit
  import rbc_pkg::*;
#(
  parameter int unsigned  CRC_W  = RBC_CRC_W,
  parameter logic [15:0]  POLY   = RBC_POLY,
  parameter int unsigned  TAIL_N = RBC_TAIL_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic mode_chk,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_last,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  input  logic chk_valid,
  output logic chk_ready,
  input  logic chk_bit,
  output logic busy,
  output logic result_valid,
  output logic mismatch
);

  rbc_phase_e phase;
  logic       mode_q;
  logic       msb;
  logic       in_acc;
  logic       out_acc;
  logic       chk_acc;
  logic       tail_acc;

  assign in_ready     = (phase == PH_LOAD);
  assign busy         = (phase == PH_TAIL);
  assign out_valid    = busy & ~mode_q;
  assign chk_ready    = busy & mode_q;
  assign result_valid = (phase == PH_DONE) & mode_q;
  assign out_bit      = msb;

  assign in_acc   = in_valid & in_ready;
  assign out_acc  = out_valid & out_ready;
  assign chk_acc  = chk_valid & chk_ready;
  assign tail_acc = out_acc | chk_acc;

  rbc_crc_reg #(
    .W    (CRC_W),
    .POLY (POLY[CRC_W-1:0]),
    .INIT ('0)
  ) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .feed_en  (in_acc),
    .feed_bit (in_bit),
    .shift_en (tail_acc),
    .msb      (msb)
  );

  rbc_seq #(
    .TAIL_N (TAIL_N)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .mode_in  (mode_chk),
    .last_acc (in_acc & in_last),
    .tail_acc (tail_acc),
    .phase    (phase),
    .mode_q   (mode_q)
  );

  rbc_cmp u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .cmp_en   (chk_acc),
    .rx_bit   (chk_bit),
    .ref_bit  (msb),
    .mismatch (mismatch)
  );

endmodule

// File: rtl/rbc_props.sv
module rbc_props (
  input logic clk,
  input logic rst_n,
  input logic clr,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic chk_ready,
  input logic busy,
  input logic result_valid,
  input logic mismatch
);

  assert_clear_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (in_ready && !busy && !mismatch && !result_valid));

  assert_ready_excl_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && busy));

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_bit)));

  assert_one_tail_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, chk_ready}));

  assert_mismatch_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !clr) |=> mismatch);

  assert_result_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> !busy);

  assert_result_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !clr) |=> result_valid);

endmodule

bind rb_crc11_unit rbc_props u_props (
  .clk          (clk),
  .rst_n        (rst_n),
  .clr          (clr),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_bit      (out_bit),
  .chk_ready    (chk_ready),
  .busy         (busy),
  .result_valid (result_valid),
  .mismatch     (mismatch)
);

// File: tb/sim_rb_crc11_unit.sv
module sim_rb_crc11_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, mode_chk = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0;
  logic out_ready = 1'b0, chk_valid = 1'b0, chk_bit = 1'b0;
  logic in_ready, out_valid, out_bit, chk_ready, busy, result_valid, mismatch;

  always #2 clk = ~clk;

  rb_crc11_unit u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode_chk(mode_chk),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .chk_valid(chk_valid), .chk_ready(chk_ready), .chk_bit(chk_bit),
    .busy(busy), .result_valid(result_valid), .mismatch(mismatch)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit armed = 0;
  bit ended = 0;

  // behavioural reference model
  int m_phase = 0;   // 0 load, 1 tail, 2 done
  int m_crc = 0;
  int m_cnt = 0;
  bit m_mode = 0;
  bit m_mis = 0;

  bit stream_q[$];

  function automatic int crc_step(int c, bit b);
    int top;
    top = ((c >> 15) & 1) ^ int'(b);
    c = (c << 1) & 'hFFFF;
    if (top != 0) c = c ^ 'h1021;
    return c;
  endfunction

  function automatic logic [10:0] ref_check();
    int c = 0;
    foreach (stream_q[i]) c = crc_step(c, stream_q[i]);
    return 11'((c >> 5) & 'h7FF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_crc = 0; m_cnt = 0; m_mode = 0; m_mis = 0;
    end else if (clr) begin
      m_phase = 0; m_crc = 0; m_cnt = 0; m_mode = mode_chk; m_mis = 0;
    end else if (m_phase == 0) begin
      if (in_valid) begin
        m_crc = crc_step(m_crc, in_bit);
        if (in_last) begin m_phase = 1; m_cnt = 0; end
      end
    end else if (m_phase == 1) begin
      if ((!m_mode && out_ready) || (m_mode && chk_valid)) begin
        if (m_mode && (chk_bit != bit'((m_crc >> 15) & 1))) m_mis = 1;
        m_crc = (m_crc << 1) & 'hFFFF;
        m_cnt++;
        if (m_cnt == 11) m_phase = 2;
      end
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !ended) begin
      check("R1/R8 in_ready", 16'(in_ready), 16'(m_phase == 0));
      check("R3 busy", 16'(busy), 16'(m_phase == 1));
      check("R4 out_valid", 16'(out_valid), 16'(m_phase == 1 && !m_mode));
      check("R5 chk_ready", 16'(chk_ready), 16'(m_phase == 1 && m_mode));
      check("R7 result_valid", 16'(result_valid), 16'(m_phase == 2 && m_mode));
      check("R6 mismatch", 16'(mismatch), 16'(m_mis));
      if (m_phase == 1 && !m_mode)
        check("R2/R4 out_bit", 16'(out_bit), 16'((m_crc >> 15) & 1));
    end
  end

  task automatic finish_run();
    ended = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !ended) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic do_clear(bit m);
    @(negedge clk); clr = 1'b1; mode_chk = m;
    @(negedge clk); clr = 1'b0; mode_chk = ~m;  // R9: pin toggles without effect
  endtask

  task automatic load_bytes(string s);
    stream_q.delete();
    for (int k = 0; k < s.len(); k++)
      for (int j = 7; j >= 0; j--) stream_q.push_back(s[k][j]);
  endtask

  task automatic feed(int flip_idx, bit gaps);
    int idx = 0;
    int n = stream_q.size();
    while (idx < n) begin
      @(negedge clk);
      if (gaps && ($urandom % 4 == 0)) begin
        in_valid = 1'b0;
        mode_chk = ~mode_chk;
      end else begin
        in_valid = 1'b1;
        in_bit   = stream_q[idx] ^ (idx == flip_idx);
        in_last  = (idx == n - 1);
        if (in_ready) idx++;
      end
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain(int nbits, output logic [10:0] v);
    int got = 0;
    v = '0;
    while (got < nbits) begin
      @(negedge clk);
      out_ready = ($urandom % 3 != 0);
      in_valid  = 1'b1;                 // R8: ignored during tail
      in_bit    = 1'($urandom);
      in_last   = 1'($urandom);
      if (out_valid && out_ready) begin
        v = {v[9:0], out_bit};
        got++;
      end
    end
    @(negedge clk); out_ready = 1'b0; in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic push_chk(logic [10:0] v);
    int sent = 0;
    while (sent < 11) begin
      @(negedge clk);
      chk_valid = ($urandom % 3 != 0);
      chk_bit   = v[10 - sent];
      in_valid  = 1'b1;
      in_bit    = 1'($urandom);
      if (chk_valid && chk_ready) sent++;
    end
    @(negedge clk); chk_valid = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    logic [10:0] got;
    logic [10:0] exp;
    repeat (3) @(negedge clk);
    armed = 1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset in_ready", 16'(in_ready), 16'd1);
    check("R1 reset mismatch", 16'(mismatch), 16'd0);

    // known vector, send mode
    do_clear(0);
    load_bytes("123456789");
    feed(-1, 1);
    drain(11, got);
    check("R2 known vector 0x18E", 16'(got), 16'h018E);
    check("R4 check bits match model", 16'(got), 16'(ref_check()));

    // compare mode, correct bits
    do_clear(1);
    feed(-1, 1);
    push_chk(11'h18E);
    @(negedge clk);
    check("R7 result after 11 bits", 16'(result_valid), 16'd1);
    check("R6 no mismatch on good bits", 16'(mismatch), 16'd0);

    // compare mode, one wrong bit early, rest correct
    do_clear(1);
    feed(-1, 0);
    push_chk(11'h18E ^ 11'h100);
    @(negedge clk);
    check("R6 sticky mismatch", 16'(mismatch), 16'd1);
    check("R7 result after corrupted compare", 16'(result_valid), 16'd1);

    // single data bit flip changes checksum
    for (int f = 0; f < 72; f += 7) begin
      do_clear(0);
      feed(f, 1);
      drain(11, got);
      checks++;
      if (got == 11'h18E) begin
        errors++;
        $display("FAIL R10 flip at %0d actual=%0h expected!=18e", f, got);
      end
    end

    // clear in the middle of a tail
    do_clear(0);
    feed(-1, 0);
    drain(4, got);
    do_clear(1);
    check("R1 clear mid-tail reopens input", 16'(in_ready), 16'd1);
    check("R1 clear mid-tail busy", 16'(busy), 16'd0);

    // random streams, both modes
    for (int t = 0; t < 30; t++) begin
      bit md = 1'($urandom);
      int len = 1 + ($urandom % 40);
      do_clear(md);
      stream_q.delete();
      for (int k = 0; k < len; k++) stream_q.push_back(1'($urandom));
      exp = ref_check();
      feed(-1, 1);
      if (!md) begin
        drain(11, got);
        check("R4 random stream check bits", 16'(got), 16'(exp));
      end else begin
        bit bad = 1'($urandom);
        push_chk(bad ? (exp ^ 11'(1 << ($urandom % 11))) : exp);
        @(negedge clk);
        check("R6 random compare mismatch", 16'(mismatch), 16'(bad));
        check("R5 random compare done", 16'(result_valid), 16'd1);
      end
    end

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule